// File: doc/BRIEF.md
# Periodic Channel Monitor with Window Thresholds

This block keeps watch over a set of analog input channels without software in the loop. Each channel has its own period timer, counted in coarse ticks of 2^TICK_LOG2 clocks. When a channel's timer runs out, the block asks an external converter for one sample of that channel over a simple request/done handshake. Only one conversion is outstanding at a time. When several timers have expired, the block serves them in order of channel number, lowest first.

When the converter hands back a result, the block checks it against that channel's lower and upper limits. Each limit has its own enable. The block then raises a one-clock interrupt pulse. A global select input decides when the pulse is raised: either after every sample, or only when a result lies outside its window. The outside-window choice is honoured only while monitoring is enabled. The interrupt pulse comes with the channel number and with flags that say which limit was crossed.

Register decode is not part of this block. All settings arrive as plain inputs.

Top module: `chan_watch`

## Requirements
- R1: After reset, `conv_req`, `irq`, `irq_below` and `irq_above` are 0.
- R2: An enabled channel with period field P is first requested (P+1)*2^TICK_LOG2 clocks after it becomes enabled. While the converter answers in time, later requests for it follow at the same spacing. With the default TICK_LOG2 of 9, this is (P+1)*512 clocks.
- R3: Requests are issued only while `mon_en` is 1 and `cont_mode` is 0. Setting `cont_mode` to 1, or `mon_en` to 0, stops all requests.
- R4: A channel whose `ch_en` bit is 0 is never requested.
- R5: When several channels are due at once, they are requested in ascending channel order. Channels that are not served stay due until they are requested.
- R6: `conv_req` is a one-clock pulse, and `conv_ch` carries the channel number in that clock. No new request is issued until `conv_done` has answered the previous one. The next request can follow one clock after the done is accepted.
- R7: With effective select 0, every accepted `conv_done` produces an `irq` pulse one clock later, with `irq_ch` set to the served channel.
- R8: With `irq_sel`=1 and `mon_en`=1, `irq` pulses only for a violation. A violation is a result below the lower limit (`irq_below`) or above the upper limit (`irq_above`). A result equal to a limit is not a violation.
- R9: A limit counts only if that channel's `min_en` (lower) or `max_en` (upper) bit is 1. `irq_below` or `irq_above` is never 1 without `irq`.
- R10: While `mon_en` is 0, `irq_sel` is ignored and the block behaves as select 0. This also applies to a conversion that completes after monitoring was switched off.
- R11: A `conv_done` that arrives while no conversion is outstanding produces no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Global periodic-monitor enable |
| cont_mode | input | 1 | Continuous conversion mode selected; blocks monitoring |
| irq_sel | input | 1 | 0: interrupt every sample; 1: only for out-of-window results |
| ch_en | input | NUM_CH | Per-channel monitor enable, bit k for channel k |
| min_en | input | NUM_CH | Per-channel lower-limit check enable |
| max_en | input | NUM_CH | Per-channel upper-limit check enable |
| period | input | NUM_CH*PER_W | Period fields; channel k at bits [k*PER_W +: PER_W] |
| lo_lim | input | NUM_CH*RES_W | Lower limits; channel k at bits [k*RES_W +: RES_W] |
| hi_lim | input | NUM_CH*RES_W | Upper limits; channel k at bits [k*RES_W +: RES_W] |
| conv_done | input | 1 | Converter finished; `conv_data` valid |
| conv_data | input | RES_W | Conversion result |
| conv_req | output | 1 | One-clock conversion request |
| conv_ch | output | CH_W | Channel of the request |
| irq | output | 1 | One-clock interrupt pulse |
| irq_ch | output | CH_W | Channel that caused `irq` |
| irq_below | output | 1 | Result was below an enabled lower limit |
| irq_above | output | 1 | Result was above an enabled upper limit |

## Verification
The bench aims at several corner cases:
- Results exactly equal to a limit, and one step beyond it. A design using the wrong comparison would interrupt on the limit or miss the step past it.
- Three channels expiring in the same clock. Serving them out of order, or dropping the losers, shows up as a wrong request sequence.
- A conversion still pending when `mon_en` falls while select is 1. A block that honours select regardless would swallow that interrupt.
- A stray done with nothing outstanding, which must not produce an interrupt.

The bench also measures the exact request timing, where an off-by-one reload gives a period one clock long or short. A cycle-accurate reference model flags any drift on every clock.

// File: rtl/cw_pkg.sv
package cw_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } cw_state_e;

   typedef struct packed {
      logic below;
      logic above;
   } cw_viol_t;
endpackage

// File: rtl/cw_period_timer.sv
// One channel's period timer. It counts down from (P+1)*2^TICK_LOG2-1, holds at zero
// (the channel is due) and reloads whenever it is stopped or a request is issued.
module cw_period_timer #(
   parameter int PER_W     = 16,
   parameter int TICK_LOG2 = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             reload,
   input  logic [PER_W-1:0] period,
   output logic             due
);
   localparam int CNT_W = PER_W + TICK_LOG2;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;

   // (P+1)*2^T - 1 == {P, T ones}; no adder required
   generate
      if (TICK_LOG2 == 0) begin : g_no_tick
         assign load_val = period;
      end else begin : g_tick
         assign load_val = {period, {TICK_LOG2{1'b1}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '1;
      end else if (!run || reload) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign due = run && (cnt == '0);
endmodule

// File: rtl/cw_prio_pick.sv
// Lowest-index-first selection among due channels (R5).
module cw_prio_pick #(
   parameter int N  = 6,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  grant
);
   always_comb begin
      any   = 1'b0;
      idx   = '0;
      grant = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) begin
            any      = 1'b1;
            idx      = IW'(k);
            grant    = '0;
            grant[k] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/cw_window_cmp.sv
// Strict window comparison; equality with a limit is inside the window (R8, R9).
module cw_window_cmp #(
   parameter int RES_W = 12
) (
   input  logic [RES_W-1:0] data,
   input  logic [RES_W-1:0] lo,
   input  logic [RES_W-1:0] hi,
   input  logic             lo_en,
   input  logic             hi_en,
   output cw_pkg::cw_viol_t viol
);
   always_comb begin
      viol.below = lo_en && (data < lo);
      viol.above = hi_en && (data > hi);
   end
endmodule

// File: rtl/chan_watch.sv
module chan_watch #(
   parameter int NUM_CH    = 6,
   parameter int PER_W     = 16,
   parameter int RES_W     = 12,
   parameter int TICK_LOG2 = 9,
   parameter int CH_W      = $clog2(NUM_CH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mon_en,
   input  logic                    cont_mode,
   input  logic                    irq_sel,
   input  logic [NUM_CH-1:0]       ch_en,
   input  logic [NUM_CH-1:0]       min_en,
   input  logic [NUM_CH-1:0]       max_en,
   input  logic [NUM_CH*PER_W-1:0] period,
   input  logic [NUM_CH*RES_W-1:0] lo_lim,
   input  logic [NUM_CH*RES_W-1:0] hi_lim,
   input  logic                    conv_done,
   input  logic [RES_W-1:0]        conv_data,
   output logic                    conv_req,
   output logic [CH_W-1:0]         conv_ch,
   output logic                    irq,
   output logic [CH_W-1:0]         irq_ch,
   output logic                    irq_below,
   output logic                    irq_above
);
   import cw_pkg::*;

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 2 || NUM_CH > 64) begin : g_bad_nch
         $error("chan_watch: NUM_CH must be within 2..64");
      end
      if (RES_W < 1 || RES_W > 16) begin : g_bad_res
         $error("chan_watch: RES_W must be within 1..16");
      end
      if (PER_W < 1 || PER_W > 32) begin : g_bad_per
         $error("chan_watch: PER_W must be within 1..32");
      end
      if (TICK_LOG2 < 0 || TICK_LOG2 > 16) begin : g_bad_tick
         $error("chan_watch: TICK_LOG2 must be within 0..16");
      end
      if (CH_W != $clog2(NUM_CH)) begin : g_bad_chw
         $error("chan_watch: CH_W must equal clog2(NUM_CH)");
      end
   endgenerate

   cw_state_e         state;
   logic [CH_W-1:0]   cur_ch;
   logic              active;
   logic              sel_eff;
   logic [NUM_CH-1:0] due;
   logic [NUM_CH-1:0] grant;
   logic              pick_any;
   logic [CH_W-1:0]   pick_idx;
   logic              issue;
   cw_viol_t          viol;

   // R3: monitoring needs the global enable and single-conversion mode
   assign active  = mon_en && !cont_mode;
   // R10: select 1 is honoured only while monitoring is enabled
   assign sel_eff = irq_sel && mon_en;
   assign issue   = (state == ST_IDLE) && pick_any;

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         cw_period_timer #(
            .PER_W    (PER_W),
            .TICK_LOG2(TICK_LOG2)
         ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (active && ch_en[k]),        // R4
            .reload(issue && grant[k]),
            .period(period[k*PER_W +: PER_W]),
            .due   (due[k])
         );
      end
   endgenerate

   cw_prio_pick #(
      .N (NUM_CH),
      .IW(CH_W)
   ) u_pick (
      .req  (due),
      .any  (pick_any),
      .idx  (pick_idx),
      .grant(grant)
   );

   cw_window_cmp #(
      .RES_W(RES_W)
   ) u_cmp (
      .data (conv_data),
      .lo   (lo_lim[cur_ch*RES_W +: RES_W]),
      .hi   (hi_lim[cur_ch*RES_W +: RES_W]),
      .lo_en(min_en[cur_ch]),
      .hi_en(max_en[cur_ch]),
      .viol (viol)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_ch    <= '0;
         conv_req  <= 1'b0;
         conv_ch   <= '0;
         irq       <= 1'b0;
         irq_ch    <= '0;
         irq_below <= 1'b0;
         irq_above <= 1'b0;
      end else begin
         conv_req  <= 1'b0;
         irq       <= 1'b0;
         irq_below <= 1'b0;
         irq_above <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (pick_any) begin
                  conv_req <= 1'b1;
                  conv_ch  <= pick_idx;
                  cur_ch   <= pick_idx;
                  state    <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               // R11: done is only accepted here
               if (conv_done) begin
                  state     <= ST_IDLE;
                  irq       <= sel_eff ? (viol.below || viol.above) : 1'b1;
                  irq_ch    <= cur_ch;
                  irq_below <= viol.below;
                  irq_above <= viol.above;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
   parameter int NUM_CH = 6,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mon_en,
   input logic              cont_mode,
   input logic              irq_sel,
   input logic [NUM_CH-1:0] ch_en,
   input logic              conv_req,
   input logic [CH_W-1:0]   conv_ch,
   input logic              conv_done,
   input logic              irq,
   input logic              irq_below,
   input logic              irq_above
);
   logic              outstanding;
   logic [NUM_CH-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
         en_q        <= '0;
      end else begin
         en_q <= ch_en;
         if (conv_req) begin
            outstanding <= 1'b1;
         end else if (conv_done) begin
            outstanding <= 1'b0;
         end
      end
   end

   assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);

   assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding |-> !conv_req);

   assert_req_only_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> $past(mon_en && !cont_mode));

   assert_req_enabled_ch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> en_q[conv_ch]);

   assert_irq_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(conv_done));

   assert_sel_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(irq_sel && mon_en)) |-> (irq_below || irq_above));

   assert_flag_needs_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_below || irq_above) |-> irq);

   assert_stray_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !outstanding && !conv_req) |=> !irq);
endmodule

bind chan_watch cw_checker #(
   .NUM_CH(NUM_CH),
   .CH_W  (CH_W)
) u_cw_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .mon_en   (mon_en),
   .cont_mode(cont_mode),
   .irq_sel  (irq_sel),
   .ch_en    (ch_en),
   .conv_req (conv_req),
   .conv_ch  (conv_ch),
   .conv_done(conv_done),
   .irq      (irq),
   .irq_below(irq_below),
   .irq_above(irq_above)
);

// File: tb/tb_chan_watch.sv
`timescale 1ns/1ps
module tb_chan_watch;
   localparam int N   = 6;
   localparam int PW  = 16;
   localparam int RW  = 12;
   localparam int TL  = 9;
   localparam int CW  = 3;
   localparam int LAT = 20;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            mon_en = 1'b0, cont_mode = 1'b0, irq_sel = 1'b0;
   logic [N-1:0]    ch_en = '0, min_en = '0, max_en = '0;
   logic [N*PW-1:0] period = '0;
   logic [N*RW-1:0] lo_lim = '0;
   logic [N*RW-1:0] hi_lim = '1;
   logic            conv_done = 1'b0;
   logic [RW-1:0]   conv_data = '0;
   logic            conv_req, irq, irq_below, irq_above;
   logic [CW-1:0]   conv_ch, irq_ch;

   chan_watch #(.NUM_CH(N), .PER_W(PW), .RES_W(RW), .TICK_LOG2(TL)) dut (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .cont_mode(cont_mode),
      .irq_sel(irq_sel), .ch_en(ch_en), .min_en(min_en), .max_en(max_en),
      .period(period), .lo_lim(lo_lim), .hi_lim(hi_lim),
      .conv_done(conv_done), .conv_data(conv_data),
      .conv_req(conv_req), .conv_ch(conv_ch), .irq(irq), .irq_ch(irq_ch),
      .irq_below(irq_below), .irq_above(irq_above));

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done_flag = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // ---------------- converter stand-in ----------------
   int unsigned   samp [N];
   int            lat_left = 0;
   logic [CW-1:0] rch = '0;
   bit            stray = 0;

   always @(posedge clk) begin
      cyc = cyc + 1;
      conv_done <= 1'b0;
      if (!rst_n) begin
         lat_left = 0;
      end else if (conv_req) begin
         lat_left = LAT;
         rch = conv_ch;
      end else if (lat_left > 0) begin
         lat_left--;
         if (lat_left == 0) begin
            conv_done <= 1'b1;
            conv_data <= RW'(samp[rch]);
         end
      end else if (stray) begin
         stray = 0;
         conv_done <= 1'b1;
         conv_data <= RW'(7);
      end
   end

   // ---------------- behavioural reference model ----------------
   longint m_cnt [N];
   bit     m_busy = 0;
   int     m_cur = 0;
   bit     m_req = 0, m_irq = 0, m_b = 0, m_a = 0;
   int     m_ch = 0, m_ich = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_cnt[k]) m_cnt[k] = (longint'(1) << (PW + TL)) - 1;
         m_busy = 0; m_req = 0; m_irq = 0; m_b = 0; m_a = 0;
      end else begin
         bit act;
         bit was_busy;
         int pick;
         act = mon_en && !cont_mode;
         was_busy = m_busy;
         pick = -1;
         m_req = 0; m_irq = 0; m_b = 0; m_a = 0;
         if (!was_busy) begin
            for (int k = 0; k < N; k++)
               if (pick < 0 && act && ch_en[k] && m_cnt[k] == 0) pick = k;
         end
         if (was_busy && conv_done) begin
            int lo, hi, d;
            lo = int'(lo_lim[m_cur*RW +: RW]);
            hi = int'(hi_lim[m_cur*RW +: RW]);
            d  = int'(conv_data);
            m_b = min_en[m_cur] && (d < lo);
            m_a = max_en[m_cur] && (d > hi);
            m_irq = (irq_sel && mon_en) ? (m_b || m_a) : 1'b1;
            m_ich = m_cur;
            m_busy = 0;
         end
         for (int k = 0; k < N; k++) begin
            longint len;
            len = (longint'(period[k*PW +: PW]) + 1) * (longint'(1) << TL) - 1;
            if (!(act && ch_en[k]) || k == pick) m_cnt[k] = len;
            else if (m_cnt[k] > 0) m_cnt[k] = m_cnt[k] - 1;
         end
         if (pick >= 0) begin
            m_req = 1; m_ch = pick; m_cur = pick; m_busy = 1;
         end
      end
   end

   // ---------------- per-clock comparison and event log ----------------
   int req_q [$];
   int reqc_q[$];
   int irq_q [$];
   int irqf_q[$];

   always @(negedge clk) begin
      if (rst_n) begin
         chk(conv_req === m_req, "R6 conv_req vs model", conv_req, m_req);
         if (m_req) chk(conv_ch === CW'(m_ch), "R5 conv_ch vs model", conv_ch, m_ch);
         chk(irq === m_irq, "R7 irq vs model", irq, m_irq);
         if (m_irq) begin
            chk(irq_ch === CW'(m_ich), "R7 irq_ch vs model", irq_ch, m_ich);
            chk(irq_below === m_b, "R8 irq_below vs model", irq_below, m_b);
            chk(irq_above === m_a, "R8 irq_above vs model", irq_above, m_a);
         end
         if (conv_req) begin req_q.push_back(int'(conv_ch)); reqc_q.push_back(cyc); end
         if (irq) begin
            irq_q.push_back(int'(irq_ch));
            irqf_q.push_back({30'd0, irq_below, irq_above});
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic go(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic clear_logs();
      req_q.delete(); reqc_q.delete(); irq_q.delete(); irqf_q.delete();
   endtask

   task automatic wait_req(input string tag);
      int n0;
      int guard;
      n0 = req_q.size();
      guard = 0;
      while (req_q.size() == n0 && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      if (guard >= 5000) chk(0, tag, 0, 1);
      go(1);
   endtask

   // one sample of channel 2 with value v; expect irq count and flags {below,above}
   task automatic one_sample(input int v, input int exp_n, input int exp_f, input string tag);
      samp[2] = v;
      clear_logs();
      wait_req(tag);
      go(LAT + 5);
      chk(irq_q.size() == exp_n, tag, irq_q.size(), exp_n);
      if (exp_n == 1 && irq_q.size() == 1) chk(irqf_q[0] == exp_f, tag, irqf_q[0], exp_f);
   endtask

   initial begin
      #(20 * 150000);
      chk(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      foreach (samp[k]) samp[k] = 2048;
      go(5);
      rst_n = 1'b1;
      go(1);
      // R1: reset state
      chk(conv_req == 1'b0, "R1 conv_req after reset", conv_req, 0);
      chk(irq == 1'b0, "R1 irq after reset", irq, 0);
      chk(irq_below == 1'b0 && irq_above == 1'b0, "R1 flags after reset", {irq_below, irq_above}, 0);

      // R2: period timing on channel 2, P=1 -> 1024 clocks
      begin
         int en_cyc;
         period[2*PW +: PW] = 16'd1;
         go(2);
         mon_en = 1'b1;
         ch_en  = 6'b000100;
         en_cyc = cyc;
         clear_logs();
         go(2100);
         chk(req_q.size() == 2, "R2 request count", req_q.size(), 2);
         if (reqc_q.size() >= 2) begin
            chk(reqc_q[0] - en_cyc == 1024, "R2 first request delay", reqc_q[0] - en_cyc, 1024);
            chk(reqc_q[1] - reqc_q[0] == 1024, "R2 request spacing", reqc_q[1] - reqc_q[0], 1024);
         end
         chk(irq_q.size() == 2, "R7 irq per sample", irq_q.size(), 2);
         if (irq_q.size() >= 1) chk(irq_q[0] == 2, "R7 irq_ch", irq_q[0], 2);
      end

      // R4/R5/R6: channels 1,3,4 expire together, channel 0 disabled
      ch_en = '0;
      period = '0;
      go(3);
      ch_en = 6'b011010;
      clear_logs();
      go(1600);
      if (req_q.size() >= 3) begin
         chk(req_q[0] == 1, "R5 first served", req_q[0], 1);
         chk(req_q[1] == 3, "R5 second served", req_q[1], 3);
         chk(req_q[2] == 4, "R5 third served", req_q[2], 4);
         chk(reqc_q[1] - reqc_q[0] == LAT + 3, "R6 wait for done", reqc_q[1] - reqc_q[0], LAT + 3);
      end else chk(0, "R5 too few requests", req_q.size(), 3);
      begin
         int bad;
         bad = 0;
         foreach (req_q[i]) if (req_q[i] == 0 || req_q[i] == 2 || req_q[i] == 5) bad++;
         chk(bad == 0, "R4 disabled channel requested", bad, 0);
      end

      // R3: continuous mode, then monitor off
      cont_mode = 1'b1;
      go(30);
      clear_logs();
      go(1200);
      chk(req_q.size() == 0, "R3 no request in continuous mode", req_q.size(), 0);
      cont_mode = 1'b0;
      mon_en = 1'b0;
      go(30);
      clear_logs();
      go(1200);
      chk(req_q.size() == 0, "R3 no request with monitor off", req_q.size(), 0);

      // R8/R9: window on channel 2 (lo=100, hi=200), flags encoded {below,above}
      lo_lim[2*RW +: RW] = 12'd100;
      hi_lim[2*RW +: RW] = 12'd200;
      min_en = 6'b000100;
      max_en = 6'b000100;
      irq_sel = 1'b1;
      mon_en = 1'b1;
      ch_en = 6'b000100;
      go(2);
      one_sample(100, 0, 0, "R8 equal to lower limit");
      one_sample(99,  1, 2, "R8 below lower limit");
      one_sample(200, 0, 0, "R8 equal to upper limit");
      one_sample(201, 1, 1, "R8 above upper limit");
      max_en = '0;
      one_sample(201, 0, 0, "R9 upper check disabled");
      max_en = 6'b000100;
      min_en = '0;
      one_sample(50,  0, 0, "R9 lower check disabled");
      one_sample(250, 1, 1, "R9 upper still enabled");
      irq_sel = 1'b0;
      one_sample(150, 1, 0, "R7 in-window with select 0");

      // R10: monitor switched off while a conversion is outstanding
      irq_sel = 1'b1;
      min_en = 6'b000100;
      samp[2] = 150;
      clear_logs();
      wait_req("R10 waiting for request");
      mon_en = 1'b0;
      go(LAT + 5);
      chk(irq_q.size() == 1, "R10 select ignored when monitor off", irq_q.size(), 1);

      // R11: stray done while idle
      clear_logs();
      stray = 1;
      go(10);
      chk(irq_q.size() == 0, "R11 stray done ignored", irq_q.size(), 0);

      finish_run();
   end
endmodule